// File: doc/BRIEF.md
# Three-Wire Configuration Register Interface

This block receives configuration words on a slow three-wire bus (a data line, a bit clock and a load strobe) and turns them into the control fields of a downconverter: the synthesizer divider values, a reference-clock output enable, an IF filter mode bit, a test-path enable and two test-point selects. Every word is 18 bits long. The first two bits give the address of one of four register slots and the other sixteen are data. The data line is sampled on each rising bit-clock edge. When the load strobe rises, the last 18 sampled bits are decoded into the addressed slot. All three bus lines are brought into the system clock domain through two-flop synchronizers and edge-detected there, so the bus can run at any rate that leaves several system clocks per bus phase.

The same three lines also act as strap inputs. When the chip enable rises, the block copies the levels on the lines and loads one of three preset frequency plans, so that a system can run without any bus traffic. A preset is taken only if the enable was low for at least `EN_LOW_CYCLES` system clocks, or was never high since reset. A shorter low glitch leaves the registers as they were.

Top module: `tri_wire_cfg`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it, every output is zero.
- R2: Bus bits are captured MSB first on rising `bus_clk`. On rising `bus_latch` only the most recent 18 captured bits form the word: bits [17:16] are the address and bits [15:0] are D15..D0. Bits sent before those 18 are discarded.
- R3: Address 0 loads `main_div` from D15..D5 and `refclk_out_en` from D1. All other data bits of this word are ignored.
- R4: Address 1 loads `swallow_div` from D15..D11, `ref_div` from D10..D2 and `test_io_en` from D0.
- R5: Address 2 loads `test_in_sel` from D15..D13, `test_out_sel` from D12..D10 and `filt_bandpass` from D1 (0 low-pass, 1 band-pass).
- R6: A word to address 3 changes no output. A write to any address leaves the fields of the other addresses unchanged.
- R7: `test_in_path` and `test_out_path` equal the matching select, except that the reserved codes 3 and 4 give path 0 (normal operation). The stored select keeps the written code.
- R8: On a qualified rise of `chip_en`, the strap code {data, clk, latch} picks a plan. Code 000 gives plan 0 (main 24, swallow 0, ref 3, band-pass). Code 100 gives plan 1 (main 21, swallow 9, ref 3, low-pass). Code 110 gives plan 2 (main 90, swallow 20, ref 9, low-pass). In every plan the clock-output enable, the test enable and both test selects are cleared.
- R9: A rise of `chip_en` loads a preset only when the enable was low for at least `EN_LOW_CYCLES` clocks, or has stayed low since reset. After a shorter low pulse all outputs keep their values.
- R10: Any strap code other than 100 or 110 selects plan 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en | input | 1 | Chip enable; a qualified rise loads a strap preset |
| bus_data | input | 1 | Serial data line and strap bit 2 |
| bus_clk | input | 1 | Serial bit clock and strap bit 1 |
| bus_latch | input | 1 | Load strobe and strap bit 0 |
| main_div | output | 11 | Main counter divide value |
| swallow_div | output | 5 | Swallow counter value |
| ref_div | output | 9 | Reference divider value |
| refclk_out_en | output | 1 | Reference clock output enable |
| filt_bandpass | output | 1 | IF filter mode, 1 = band-pass |
| test_io_en | output | 1 | Test input/output enable |
| test_in_sel | output | 3 | Stored test input select code |
| test_out_sel | output | 3 | Stored test output select code |
| test_in_path | output | 3 | Effective test input point |
| test_out_path | output | 3 | Effective test output point |

## Verification
On every cycle the assertions check four things. The outputs move only after a decoded word or a preset load. A word to address 3 never moves them. A preset always clears the enable and select fields. The effective test paths are never a reserved code and never differ from their select except by falling back to normal. Only the bench scenarios can show the field positions within each address, MSB-first ordering with surplus bits discarded, the values of each strap plan, and whether a short enable pulse is rejected, because these depend on the bit sequences and timing sent.

// File: rtl/tri_wire_cfg_pkg.sv
// Package: widths and field record for the three-wire configuration block.
// Assumes field widths are fixed by the word layout decoded by the bank.
package tri_wire_cfg_pkg;
    localparam int WORD_W = 18;
    localparam int MAIN_W = 11;
    localparam int SWAL_W = 5;
    localparam int REF_W  = 9;
    localparam int SEL_W  = 3;

    typedef struct packed {
        logic [MAIN_W-1:0] main_div;
        logic [SWAL_W-1:0] swal_div;
        logic [REF_W-1:0]  ref_div;
        logic              clk_en;
        logic              bandpass;
        logic              test_en;
        logic [SEL_W-1:0]  tin;
        logic [SEL_W-1:0]  tout;
    } cfg_t;

    // Map a stored select code to the point actually used (reserved -> normal).
    function automatic logic [SEL_W-1:0] eff_path(input logic [SEL_W-1:0] code);
        return (code == SEL_W'(3) || code == SEL_W'(4)) ? '0 : code;
    endfunction
endpackage

// File: rtl/tri_wire_cfg_sync.sv
// Two-flop synchronizer for W asynchronous level inputs.
// Assumes the inputs hold each level for several destination clocks.
module tri_wire_cfg_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    // Two register stages into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/tri_wire_cfg_rx.sv
// Serial receiver: shifts data on rising bus clock and pulses frm_vld with
// the last WORD_W bits on rising latch. Assumes synchronized inputs.
module tri_wire_cfg_rx
    import tri_wire_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdat,
    input  logic              sclk,
    input  logic              slat,
    output logic              frm_vld,
    output logic [WORD_W-1:0] frm
);
    logic sclk_q, slat_q;
    logic sclk_rise, slat_rise;

    assign sclk_rise = sclk & ~sclk_q;
    assign slat_rise = slat & ~slat_q;

    // Edge history of the bus clock and latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            slat_q <= 1'b0;
        end else begin
            sclk_q <= sclk;
            slat_q <= slat;
        end
    end

    // Shift register: newest bit enters at the LSB, oldest falls off the top.
    always_ff @(posedge clk) begin
        if (!rst_n)         frm <= '0;
        else if (sclk_rise) frm <= {frm[WORD_W-2:0], sdat};
    end

    // One-cycle word strobe on a latch rise.
    always_ff @(posedge clk) begin
        if (!rst_n) frm_vld <= 1'b0;
        else        frm_vld <= slat_rise;
    end
endmodule

// File: rtl/tri_wire_cfg_bank.sv
// Register bank: decodes addressed words into fields and loads strap presets
// on a qualified enable rise. Assumes frm is stable while frm_vld is high.
module tri_wire_cfg_bank
    import tri_wire_cfg_pkg::*;
#(
    parameter int EN_LOW_CYCLES = 2_500_000,
    parameter int P0_MAIN = 24, parameter int P0_SWAL = 0,  parameter int P0_REF = 3, parameter bit P0_BP = 1'b1,
    parameter int P1_MAIN = 21, parameter int P1_SWAL = 9,  parameter int P1_REF = 3, parameter bit P1_BP = 1'b0,
    parameter int P2_MAIN = 90, parameter int P2_SWAL = 20, parameter int P2_REF = 9, parameter bit P2_BP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_vld,
    input  logic [WORD_W-1:0] frm,
    input  logic              en,
    input  logic [2:0]        strap,
    output cfg_t              cfg,
    output logic              preset_ld
);
    localparam int CNT_W = $clog2(EN_LOW_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(EN_LOW_CYCLES);

    logic             en_q;
    logic [CNT_W-1:0] low_cnt;
    logic [1:0]       addr;
    logic [15:0]      dat;
    cfg_t             preset;

    assign addr      = frm[WORD_W-1:WORD_W-2];
    assign dat       = frm[15:0];
    assign preset_ld = en & ~en_q & (low_cnt == CNT_MAX);

    // Strap code to preset plan; unlisted codes fall back to plan 0.
    always_comb begin
        preset = '0;
        case (strap)
            3'b100: begin
                preset.main_div = MAIN_W'(P1_MAIN);
                preset.swal_div = SWAL_W'(P1_SWAL);
                preset.ref_div  = REF_W'(P1_REF);
                preset.bandpass = P1_BP;
            end
            3'b110: begin
                preset.main_div = MAIN_W'(P2_MAIN);
                preset.swal_div = SWAL_W'(P2_SWAL);
                preset.ref_div  = REF_W'(P2_REF);
                preset.bandpass = P2_BP;
            end
            default: begin
                preset.main_div = MAIN_W'(P0_MAIN);
                preset.swal_div = SWAL_W'(P0_SWAL);
                preset.ref_div  = REF_W'(P0_REF);
                preset.bandpass = P0_BP;
            end
        endcase
    end

    // Enable history and low-time counter; reset counts as a full low period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            low_cnt <= CNT_MAX;
        end else begin
            en_q <= en;
            if (en)                     low_cnt <= '0;
            else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
        end
    end

    // Field storage: preset wins over a word arriving in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (preset_ld) begin
            cfg <= preset;
        end else if (frm_vld) begin
            case (addr)
                2'd0: begin
                    cfg.main_div <= dat[15:5];
                    cfg.clk_en   <= dat[1];
                end
                2'd1: begin
                    cfg.swal_div <= dat[15:11];
                    cfg.ref_div  <= dat[10:2];
                    cfg.test_en  <= dat[0];
                end
                2'd2: begin
                    cfg.tin      <= dat[15:13];
                    cfg.tout     <= dat[12:10];
                    cfg.bandpass <= dat[1];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tri_wire_cfg.sv
// Top: synchronizes the bus and enable, receives words, holds the fields and
// drives the decoded control outputs. Assumes bus phases span >= 4 clocks.
module tri_wire_cfg
    import tri_wire_cfg_pkg::*;
#(
    parameter int EN_LOW_CYCLES = 2_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              bus_data,
    input  logic              bus_clk,
    input  logic              bus_latch,
    output logic [MAIN_W-1:0] main_div,
    output logic [SWAL_W-1:0] swallow_div,
    output logic [REF_W-1:0]  ref_div,
    output logic              refclk_out_en,
    output logic              filt_bandpass,
    output logic              test_io_en,
    output logic [SEL_W-1:0]  test_in_sel,
    output logic [SEL_W-1:0]  test_out_sel,
    output logic [SEL_W-1:0]  test_in_path,
    output logic [SEL_W-1:0]  test_out_path
);
    logic [3:0]        sync_q;
    logic              frm_vld;
    logic [WORD_W-1:0] frm;
    logic              preset_ld;
    cfg_t              cfg;

    tri_wire_cfg_sync #(.W(4)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({chip_en, bus_data, bus_clk, bus_latch}),
        .sync_out (sync_q)
    );

    tri_wire_cfg_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sdat    (sync_q[2]),
        .sclk    (sync_q[1]),
        .slat    (sync_q[0]),
        .frm_vld (frm_vld),
        .frm     (frm)
    );

    tri_wire_cfg_bank #(.EN_LOW_CYCLES(EN_LOW_CYCLES)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_vld   (frm_vld),
        .frm       (frm),
        .en        (sync_q[3]),
        .strap     (sync_q[2:0]),
        .cfg       (cfg),
        .preset_ld (preset_ld)
    );

    assign main_div      = cfg.main_div;
    assign swallow_div   = cfg.swal_div;
    assign ref_div       = cfg.ref_div;
    assign refclk_out_en = cfg.clk_en;
    assign filt_bandpass = cfg.bandpass;
    assign test_io_en    = cfg.test_en;
    assign test_in_sel   = cfg.tin;
    assign test_out_sel  = cfg.tout;
    assign test_in_path  = eff_path(cfg.tin);
    assign test_out_path = eff_path(cfg.tout);
endmodule

// File: rtl/tri_wire_cfg_chk.sv
// Checker bound to the top: relates output movement to word and preset strobes.
module tri_wire_cfg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frm_vld,
    input logic [17:0] frm,
    input logic        preset_ld,
    input logic [10:0] main_div,
    input logic [4:0]  swallow_div,
    input logic [8:0]  ref_div,
    input logic        refclk_out_en,
    input logic        filt_bandpass,
    input logic        test_io_en,
    input logic [2:0]  test_in_sel,
    input logic [2:0]  test_out_sel,
    input logic [2:0]  test_in_path,
    input logic [2:0]  test_out_path
);
    logic [41:0] all_out;
    assign all_out = {main_div, swallow_div, ref_div, refclk_out_en, filt_bandpass,
                      test_io_en, test_in_sel, test_out_sel, test_in_path, test_out_path};

    // R1: reset clears every output.
    p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> (all_out == '0));

    // R2: outputs only move after a word strobe or a preset load.
    p_quiet_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_vld && !preset_ld) |=> $stable(all_out));

    // R6: a word to address 3 leaves all outputs alone.
    p_addr3_noop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm[17:16] == 2'b11 && !preset_ld) |=> $stable(all_out));

    // R7: effective path is either normal or the stored code, never reserved.
    p_path_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_in_path == 3'd0 || test_in_path == test_in_sel) &&
        (test_out_path == 3'd0 || test_out_path == test_out_sel) &&
        test_in_path != 3'd3 && test_in_path != 3'd4 &&
        test_out_path != 3'd3 && test_out_path != 3'd4);

    // R8: a preset clears the enables and test selects.
    p_preset_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        preset_ld |=> (!refclk_out_en && !test_io_en && test_in_sel == 3'd0 && test_out_sel == 3'd0));
endmodule

bind tri_wire_cfg tri_wire_cfg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frm_vld       (frm_vld),
    .frm           (frm),
    .preset_ld     (preset_ld),
    .main_div      (main_div),
    .swallow_div   (swallow_div),
    .ref_div       (ref_div),
    .refclk_out_en (refclk_out_en),
    .filt_bandpass (filt_bandpass),
    .test_io_en    (test_io_en),
    .test_in_sel   (test_in_sel),
    .test_out_sel  (test_out_sel),
    .test_in_path  (test_in_path),
    .test_out_path (test_out_path)
);

// File: tb/tri_wire_cfg_test.sv
module tri_wire_cfg_test;
    localparam int LOWC = 40;
    localparam int NVEC = 10;
    // Word table walked by the main loop.
    localparam logic [17:0] VEC [NVEC] = '{
        {2'b00, 11'h5A3, 3'b101, 1'b1, 1'b1},   // R3 with stray bits set
        {2'b01, 5'h13, 9'h1A5, 1'b1, 1'b1},     // R4
        {2'b10, 3'd5, 3'd6, 8'hFF, 1'b1, 1'b0}, // R5
        {2'b11, 16'hFFFF},                      // R6
        {2'b10, 3'd3, 3'd4, 8'h00, 1'b0, 1'b1}, // R7 reserved codes
        {2'b10, 3'd1, 3'd2, 8'h00, 1'b1, 1'b0}, // R7
        {2'b10, 3'd7, 3'd0, 8'h00, 1'b0, 1'b0}, // R5
        {2'b00, 11'h7FF, 5'b00000},             // R3
        {2'b01, 5'h00, 9'h1FF, 1'b0, 1'b0},     // R4
        {2'b11, 16'h0000}                       // R6
    };

    logic clk = 0, rst_n = 0, chip_en = 0, bd = 0, bc = 0, bl = 0;
    logic [10:0] main_div; logic [4:0] swallow_div; logic [8:0] ref_div;
    logic refclk_out_en, filt_bandpass, test_io_en;
    logic [2:0] test_in_sel, test_out_sel, test_in_path, test_out_path;
    int checks = 0, fails = 0;
    bit done = 0;

    // Expected model.
    logic [10:0] m_main; logic [4:0] m_swal; logic [8:0] m_ref;
    logic m_ck, m_bp, m_te; logic [2:0] m_ti, m_to;

    always #2 clk = ~clk;

    tri_wire_cfg #(.EN_LOW_CYCLES(LOWC)) uut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .bus_data(bd), .bus_clk(bc), .bus_latch(bl),
        .main_div(main_div), .swallow_div(swallow_div), .ref_div(ref_div),
        .refclk_out_en(refclk_out_en), .filt_bandpass(filt_bandpass), .test_io_en(test_io_en),
        .test_in_sel(test_in_sel), .test_out_sel(test_out_sel),
        .test_in_path(test_in_path), .test_out_path(test_out_path));

    function automatic logic [2:0] mpath(input logic [2:0] s);
        return (s == 3'd3 || s == 3'd4) ? 3'd0 : s;
    endfunction

    task automatic model_word(input logic [17:0] w);
        case (w[17:16])
            2'b00: begin m_main = w[15:5]; m_ck = w[1]; end
            2'b01: begin m_swal = w[15:11]; m_ref = w[10:2]; m_te = w[0]; end
            2'b10: begin m_ti = w[15:13]; m_to = w[12:10]; m_bp = w[1]; end
            default: ;
        endcase
    endtask

    task automatic model_plan(input logic [10:0] mn, input logic [4:0] sw, input logic [8:0] rf, input logic bp);
        m_main = mn; m_swal = sw; m_ref = rf; m_bp = bp;
        m_ck = 0; m_te = 0; m_ti = 0; m_to = 0;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bits(input int n, input logic [31:0] v);
        for (int i = n - 1; i >= 0; i--) begin
            bd = v[i]; wait_clks(4);
            bc = 1;    wait_clks(4);
            bc = 0;    wait_clks(4);
        end
        bl = 1; wait_clks(8);
        bl = 0; bd = 0; wait_clks(8);
    endtask

    task automatic check_all(input string tag);
        logic [41:0] act, exp;
        @(negedge clk);
        act = {main_div, swallow_div, ref_div, refclk_out_en, filt_bandpass, test_io_en,
               test_in_sel, test_out_sel, test_in_path, test_out_path};
        exp = {m_main, m_swal, m_ref, m_ck, m_bp, m_te, m_ti, m_to, mpath(m_ti), mpath(m_to)};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic strap_rise(input logic [2:0] code, input int low_len);
        chip_en = 0; wait_clks(low_len);
        {bd, bc, bl} = code; wait_clks(6);
        chip_en = 1; wait_clks(8);
        {bd, bc, bl} = 3'b000; wait_clks(8);
    endtask

    initial begin
        model_plan('0, '0, '0, 0);
        wait_clks(4);
        check_all("R1 in reset");
        rst_n = 1;
        @(posedge clk); #1;
        check_all("R1 after reset");

        // First rise after reset qualifies without a low wait.
        strap_rise(3'b000, 0);
        model_plan(11'd24, 5'd0, 9'd3, 1'b1);
        check_all("R8 plan0 from reset");

        // Table walk of addressed writes.
        for (int k = 0; k < NVEC; k++) begin
            send_bits(18, {14'h0, VEC[k]});
            model_word(VEC[k]);
            check_all($sformatf("R3 R4 R5 R6 R7 vec %0d", k));
        end

        // R2: leading surplus bits are discarded.
        send_bits(23, {9'h0, 5'b10111, 2'b00, 11'h2C5, 5'b00010});
        model_word({2'b00, 11'h2C5, 5'b00010});
        check_all("R2 surplus bits");

        // R8 plans via straps after a long low.
        strap_rise(3'b100, LOWC + 20);
        model_plan(11'd21, 5'd9, 9'd3, 1'b0);
        check_all("R8 plan1");
        strap_rise(3'b110, LOWC + 20);
        model_plan(11'd90, 5'd20, 9'd9, 1'b0);
        check_all("R8 plan2");
        strap_rise(3'b010, LOWC + 20);
        model_plan(11'd24, 5'd0, 9'd3, 1'b1);
        check_all("R10 clk-only strap");

        // R9: a short low pulse keeps written values.
        send_bits(18, {14'h0, 2'b01, 5'h0A, 9'h055, 1'b0, 1'b1});
        model_word({2'b01, 5'h0A, 9'h055, 1'b0, 1'b1});
        check_all("R4 pre-glitch");
        strap_rise(3'b100, 10);
        check_all("R9 short low ignored");

        // R6: address 3 after preset state leaves everything.
        send_bits(18, {14'h0, 2'b11, 16'hA5A5});
        check_all("R6 addr3 final");

        // R1: reset mid-run.
        rst_n = 0; wait_clks(3);
        model_plan('0, '0, '0, 0);
        check_all("R1 mid-run reset");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule